// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block sequences the control of a multicycle datapath by stepping through a small fixed microprogram. A 4-bit state register is the microprogram counter. Each counter value selects one microinstruction from a case-coded store. That microinstruction drives the ALU operation, the two ALU operand selects, the register-file action, the memory action and the PC write source. It also carries a 2-bit sequencing code that picks the next counter value.

The sequencing code has four meanings: step to the next microinstruction, jump through the primary opcode table, jump through the secondary opcode table, or go back to the fetch microinstruction. The datapath presents the current instruction's 6-bit opcode, and only the two table lookups use it. A load takes five cycles from fetch back to fetch. A store and a register-to-register operation each take four, and a compare-and-branch takes three. An opcode that a table does not list goes back to fetch.

The reset input is asynchronous and active low. Its release passes through two flops before the counter leaves fetch.

Top module: `useq_ctrl`

## Requirements
- R1: While reset is active the counter is 0 and the outputs show the fetch microinstruction. After the reset input rises, the counter stays at 0 for two more rising edges and leaves 0 at the third. Asserting reset at any time forces the counter to 0 without waiting for a clock edge.
- R2: When the sequencing code is 0 (next), the counter on the following edge equals its previous value plus one. The counter never exceeds 8.
- R3: Counter 0 (fetch) has these fields:
  - ALU operation 0 (add).
  - Operand A select 0 (PC).
  - Operand B select 1 (constant 4).
  - Register-file action 0 (idle).
  - Memory action 1 (read at PC).
  - PC write 1 (from the ALU result).
  - Sequencing code 0.
- R4: Counter 1 (decode) has ALU operation 0, operand A 0, operand B 3 (sign-extended offset shifted left by 2), register-file action 1 (read), memory action 0, PC write 0 and sequencing code 1 (primary table).
- R5: The primary table maps opcodes 0x23 and 0x2B to counter 2, opcode 0x00 to counter 6 and opcode 0x04 to counter 8.
- R6: The secondary table maps opcode 0x23 to counter 3 and opcode 0x2B to counter 5.
- R7: An opcode that the selected table does not list sends the counter to 0.
- R8: The memory-address and load microinstructions are:
  - Counter 2 has ALU operation 0, operand A 1 (register A), operand B 2 (sign-extended offset) and sequencing code 2 (secondary table).
  - Counter 3 has memory action 2 (read at the ALU address) and sequencing code 0.
  - Counter 4 has register-file action 3 (write memory data) and sequencing code 3.
  - All fields not listed are 0.
- R9: Counter 5 has memory action 3 (write at the ALU address) and sequencing code 3. All other fields are 0.
- R10: The register-to-register microinstructions are:
  - Counter 6 has ALU operation 2 (function field), operand A 1, operand B 0 (register B) and sequencing code 0.
  - Counter 7 has register-file action 2 (write ALU result) and sequencing code 3.
  - All fields not listed are 0.
- R11: Counter 8 has ALU operation 1 (subtract), operand A 1, operand B 0, PC write 2 (branch target when the operands are equal) and sequencing code 3. All other fields are 0.
- R12: When the sequencing code is 3 (fetch), the counter on the following edge is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode of the current instruction |
| upc | output | 4 | Microprogram counter |
| alu_op | output | 2 | ALU operation code |
| alu_src_a | output | 1 | ALU operand A select |
| alu_src_b | output | 2 | ALU operand B select |
| rf_act | output | 2 | Register-file action |
| mem_act | output | 2 | Memory action |
| pc_wr | output | 2 | PC write source |
| seq | output | 2 | Sequencing code of the current microinstruction |

## Verification
The dispatch assertions assume that the opcode input is a defined value on every edge at which a table lookup takes place. They compare the next counter with the opcode seen on that same edge. The bench drives the opcode only at falling edges and always with known values.

The bench steps through all 64 opcodes, each starting from fetch. It also changes the opcode between the primary and secondary lookups, so that the secondary table gets an opcode it does not list. Because the bench does this openly, the assertions do not assume that the opcode stays the same for a whole instruction.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int OPC_W = 6;
  localparam int UPC_W = 4;

  typedef enum logic [1:0] {SQ_NEXT = 2'd0, SQ_DISP1 = 2'd1, SQ_DISP2 = 2'd2, SQ_FETCH = 2'd3} seq_e;
  typedef enum logic [1:0] {ALU_ADD = 2'd0, ALU_SUB = 2'd1, ALU_FUNCT = 2'd2, ALU_RSVD = 2'd3} alu_e;
  typedef enum logic      {SA_PC = 1'b0, SA_REGA = 1'b1} srca_e;
  typedef enum logic [1:0] {SB_REGB = 2'd0, SB_FOUR = 2'd1, SB_OFFS = 2'd2, SB_OFFS4 = 2'd3} srcb_e;
  typedef enum logic [1:0] {RF_IDLE = 2'd0, RF_READ = 2'd1, RF_WR_ALU = 2'd2, RF_WR_MEM = 2'd3} rf_e;
  typedef enum logic [1:0] {MEM_IDLE = 2'd0, MEM_RD_PC = 2'd1, MEM_RD_ALU = 2'd2, MEM_WR_ALU = 2'd3} mem_e;
  typedef enum logic [1:0] {PCW_NONE = 2'd0, PCW_ALU = 2'd1, PCW_BR_EQ = 2'd2, PCW_RSVD = 2'd3} pcw_e;

  typedef struct packed {
    alu_e  alu;
    srca_e src_a;
    srcb_e src_b;
    rf_e   rf;
    mem_e  mem;
    pcw_e  pcw;
    seq_e  seq;
  } uinstr_t;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;

  localparam logic [UPC_W-1:0] UA_FETCH  = 4'd0;
  localparam logic [UPC_W-1:0] UA_DECODE = 4'd1;
  localparam logic [UPC_W-1:0] UA_MADDR  = 4'd2;
  localparam logic [UPC_W-1:0] UA_LOAD   = 4'd3;
  localparam logic [UPC_W-1:0] UA_LDWB   = 4'd4;
  localparam logic [UPC_W-1:0] UA_STORE  = 4'd5;
  localparam logic [UPC_W-1:0] UA_ALUOP  = 4'd6;
  localparam logic [UPC_W-1:0] UA_ALUWB  = 4'd7;
  localparam logic [UPC_W-1:0] UA_BRANCH = 4'd8;

  // Primary table: instruction class after decode.
  function automatic logic [UPC_W-1:0] lookup_primary(input logic [OPC_W-1:0] op);
    case (op)
      OPC_LOAD, OPC_STORE: lookup_primary = UA_MADDR;
      OPC_RTYPE:           lookup_primary = UA_ALUOP;
      OPC_BEQ:             lookup_primary = UA_BRANCH;
      default:             lookup_primary = UA_FETCH;
    endcase
  endfunction

  // Secondary table: direction of a memory access.
  function automatic logic [UPC_W-1:0] lookup_secondary(input logic [OPC_W-1:0] op);
    case (op)
      OPC_LOAD:  lookup_secondary = UA_LOAD;
      OPC_STORE: lookup_secondary = UA_STORE;
      default:   lookup_secondary = UA_FETCH;
    endcase
  endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int AW = UPC_W
) (
  input  logic [AW-1:0] addr,
  output uinstr_t       word
);

  always_comb begin
    word = '{alu: ALU_ADD, src_a: SA_PC, src_b: SB_REGB, rf: RF_IDLE,
             mem: MEM_IDLE, pcw: PCW_NONE, seq: SQ_FETCH};
    case (addr)
      UA_FETCH: begin
        word.src_b = SB_FOUR;
        word.mem   = MEM_RD_PC;
        word.pcw   = PCW_ALU;
        word.seq   = SQ_NEXT;
      end
      UA_DECODE: begin
        word.src_b = SB_OFFS4;
        word.rf    = RF_READ;
        word.seq   = SQ_DISP1;
      end
      UA_MADDR: begin
        word.src_a = SA_REGA;
        word.src_b = SB_OFFS;
        word.seq   = SQ_DISP2;
      end
      UA_LOAD: begin
        word.mem = MEM_RD_ALU;
        word.seq = SQ_NEXT;
      end
      UA_LDWB:  word.rf  = RF_WR_MEM;
      UA_STORE: word.mem = MEM_WR_ALU;
      UA_ALUOP: begin
        word.alu   = ALU_FUNCT;
        word.src_a = SA_REGA;
        word.seq   = SQ_NEXT;
      end
      UA_ALUWB: word.rf = RF_WR_ALU;
      UA_BRANCH: begin
        word.alu   = ALU_SUB;
        word.src_a = SA_REGA;
        word.pcw   = PCW_BR_EQ;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int OW     = OPC_W,
  parameter int AW     = UPC_W,
  parameter int N_TBL  = 2
) (
  input  logic [OW-1:0]       opcode,
  output logic [N_TBL*AW-1:0] targets
);

  for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
    if (t == 0) begin : g_primary
      assign targets[t*AW +: AW] = lookup_primary(opcode);
    end else begin : g_secondary
      assign targets[t*AW +: AW] = lookup_secondary(opcode);
    end
  end

endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int AW = UPC_W
) (
  input  logic [AW-1:0] upc,
  input  seq_e          seq,
  input  logic [AW-1:0] tgt_primary,
  input  logic [AW-1:0] tgt_secondary,
  output logic [AW-1:0] upc_nxt
);

  always_comb begin
    case (seq)
      SQ_NEXT:  upc_nxt = upc + AW'(1);
      SQ_DISP1: upc_nxt = tgt_primary;
      SQ_DISP2: upc_nxt = tgt_secondary;
      default:  upc_nxt = '0;
    endcase
  end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int OP_W = OPC_W,
  parameter int PC_W = UPC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode,
  output logic [PC_W-1:0] upc,
  output logic [1:0]      alu_op,
  output logic            alu_src_a,
  output logic [1:0]      alu_src_b,
  output logic [1:0]      rf_act,
  output logic [1:0]      mem_act,
  output logic [1:0]      pc_wr,
  output logic [1:0]      seq
);

  localparam int N_TBL = 2;

  logic                  rst_meta_n, rst_sync_n;
  logic [PC_W-1:0]       upc_q, upc_nxt;
  logic [N_TBL*PC_W-1:0] tgts;
  uinstr_t               uword;

  // Reset: asserts at once, releases after two edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  useq_rom #(.AW(PC_W)) i_rom (
    .addr (upc_q),
    .word (uword)
  );

  useq_dispatch #(.OW(OP_W), .AW(PC_W), .N_TBL(N_TBL)) i_dispatch (
    .opcode  (opcode),
    .targets (tgts)
  );

  useq_next #(.AW(PC_W)) i_next (
    .upc           (upc_q),
    .seq           (uword.seq),
    .tgt_primary   (tgts[0 +: PC_W]),
    .tgt_secondary (tgts[PC_W +: PC_W]),
    .upc_nxt       (upc_nxt)
  );

  // Microprogram counter, the only state of the sequencer.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) upc_q <= '0;
    else             upc_q <= upc_nxt;
  end

  assign upc       = upc_q;
  assign alu_op    = uword.alu;
  assign alu_src_a = uword.src_a;
  assign alu_src_b = uword.src_b;
  assign rf_act    = uword.rf;
  assign mem_act   = uword.mem;
  assign pc_wr     = uword.pcw;
  assign seq       = uword.seq;

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seq == SQ_NEXT) |=> (upc == $past(upc) + PC_W'(1)));

  assert_range_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upc <= UA_BRANCH));

  assert_return_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seq == SQ_FETCH) |=> (upc == UA_FETCH));

  assert_prim_rtype_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seq == SQ_DISP1 && opcode == OPC_RTYPE) |=> (upc == UA_ALUOP));

  assert_prim_beq_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seq == SQ_DISP1 && opcode == OPC_BEQ) |=> (upc == UA_BRANCH));

  assert_prim_mem_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seq == SQ_DISP1 && (opcode == OPC_LOAD || opcode == OPC_STORE)) |=> (upc == UA_MADDR));

  assert_sec_load_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seq == SQ_DISP2 && opcode == OPC_LOAD) |=> (upc == UA_LOAD));

  assert_sec_store_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seq == SQ_DISP2 && opcode == OPC_STORE) |=> (upc == UA_STORE));

  assert_unlisted_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seq == SQ_DISP1 && opcode != OPC_RTYPE && opcode != OPC_BEQ &&
     opcode != OPC_LOAD && opcode != OPC_STORE) |=> (upc == UA_FETCH));

endmodule

// File: tb/test_useq_ctrl.sv
`timescale 1ns/1ps
module test_useq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] opcode;
  logic [3:0] upc;
  logic [1:0] alu_op, alu_src_b, rf_act, mem_act, pc_wr, seq;
  logic       alu_src_a;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  always #5 clk = ~clk;

  useq_ctrl i_useq_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .upc(upc),
    .alu_op(alu_op), .alu_src_a(alu_src_a), .alu_src_b(alu_src_b),
    .rf_act(rf_act), .mem_act(mem_act), .pc_wr(pc_wr), .seq(seq)
  );

  // Expected fields {alu,srcA,srcB,rf,mem,pcw,seq} per counter, from R3,R4,R8..R11.
  function automatic logic [12:0] exp_word(input int a);
    case (a)
      0: exp_word = {2'd0, 1'b0, 2'd1, 2'd0, 2'd1, 2'd1, 2'd0};
      1: exp_word = {2'd0, 1'b0, 2'd3, 2'd1, 2'd0, 2'd0, 2'd1};
      2: exp_word = {2'd0, 1'b1, 2'd2, 2'd0, 2'd0, 2'd0, 2'd2};
      3: exp_word = {2'd0, 1'b0, 2'd0, 2'd0, 2'd2, 2'd0, 2'd0};
      4: exp_word = {2'd0, 1'b0, 2'd0, 2'd3, 2'd0, 2'd0, 2'd3};
      5: exp_word = {2'd0, 1'b0, 2'd0, 2'd0, 2'd3, 2'd0, 2'd3};
      6: exp_word = {2'd2, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0};
      7: exp_word = {2'd0, 1'b0, 2'd0, 2'd2, 2'd0, 2'd0, 2'd3};
      8: exp_word = {2'd1, 1'b1, 2'd0, 2'd0, 2'd0, 2'd2, 2'd3};
      default: exp_word = 13'h0;
    endcase
  endfunction

  function automatic string field_tag(input int a);
    case (a)
      0: field_tag = "R3";
      1: field_tag = "R4";
      2, 3, 4: field_tag = "R8";
      5: field_tag = "R9";
      6, 7: field_tag = "R10";
      default: field_tag = "R11";
    endcase
  endfunction

  // Next counter and the requirement governing the step (R2,R5,R6,R7,R12).
  function automatic int exp_next(input int a, input logic [5:0] op, output string tag);
    case (a)
      0, 3, 6: begin exp_next = a + 1; tag = "R2"; end
      1: begin
        if (op == 6'h23 || op == 6'h2B) begin exp_next = 2; tag = "R5"; end
        else if (op == 6'h00)           begin exp_next = 6; tag = "R5"; end
        else if (op == 6'h04)           begin exp_next = 8; tag = "R5"; end
        else                            begin exp_next = 0; tag = "R7"; end
      end
      2: begin
        if (op == 6'h23)      begin exp_next = 3; tag = "R6"; end
        else if (op == 6'h2B) begin exp_next = 5; tag = "R6"; end
        else                  begin exp_next = 0; tag = "R7"; end
      end
      default: begin exp_next = 0; tag = "R12"; end
    endcase
  endfunction

  task automatic check_fields(input int a, input string tag);
    logic [12:0] act;
    act = {alu_op, alu_src_a, alu_src_b, rf_act, mem_act, pc_wr, seq};
    n_checks++;
    if (act !== exp_word(a)) begin
      n_fail++;
      $display("FAIL %s fields at upc %0d: actual %h expected %h", tag, a, act, exp_word(a));
    end
  endtask

  task automatic check_upc(input int e, input string tag);
    n_checks++;
    if (upc !== 4'(e)) begin
      n_fail++;
      $display("FAIL %s counter: actual %0d expected %0d", tag, upc, e);
    end
  endtask

  // Release reset at a falling edge; counter leaves 0 at the third rising edge (R1).
  task automatic release_reset();
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check_upc(0, "R1");
    @(posedge clk); @(negedge clk);
    check_upc(0, "R1");
  endtask

  // Run one instruction from fetch back to fetch, checking each cycle.
  task automatic run_instr(input logic [5:0] op);
    int    a;
    int    nx;
    string tg;
    opcode = op;
    a = 0;
    for (int step = 0; step < 8; step++) begin
      check_upc(a, "R12");
      check_fields(a, field_tag(a));
      nx = exp_next(a, op, tg);
      @(posedge clk); @(negedge clk);
      check_upc(nx, tg);
      a = nx;
      if (a == 0) break;
    end
  endtask

  initial begin
    rst_n  = 1'b0;
    opcode = 6'h00;
    repeat (3) @(negedge clk);
    check_upc(0, "R1");
    check_fields(0, "R1");
    release_reset();

    // Exhaustive sweep over all opcodes: R2..R12.
    for (int op = 0; op < 64; op++) run_instr(6'(op));

    // Secondary table with an unlisted opcode (R7).
    opcode = 6'h23;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check_upc(2, "R5");
    opcode = 6'h04;
    @(posedge clk); @(negedge clk);
    check_upc(0, "R7");

    // Store chosen late at the secondary lookup (R6).
    opcode = 6'h00;
    @(posedge clk); @(negedge clk);
    opcode = 6'h2B;
    @(posedge clk); @(negedge clk);
    check_upc(2, "R5");
    @(posedge clk); @(negedge clk);
    check_upc(5, "R6");
    check_fields(5, "R9");
    @(posedge clk); @(negedge clk);
    check_upc(0, "R12");

    // Asynchronous reset in the middle of a load (R1).
    opcode = 6'h23;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    check_upc(3, "R6");
    #2 rst_n = 1'b0;
    #1 check_upc(0, "R1");
    check_fields(0, "R1");
    @(negedge clk);
    release_reset();
    run_instr(6'h23);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule